// File: doc/BRIEF.md
# Host-to-Module Command Frame Packer and Checker

This block carries commands and write data from a memory host to a buffered memory module across ten serial lanes. On the host side it takes one typed payload at a time: a 2-bit frame type, a 24-bit lead command and a 72-bit field whose contents depend on the type. It zeroes the field bits that the type leaves unused and appends a 22-bit CRC over the 98 payload bits. It then shifts the resulting 120-bit frame out ten bits per cycle over twelve cycles, and can take the next payload on the last beat, so frames leave without gaps.

On the module side, the receiving half collects twelve lane beats that start at a marked first beat and recomputes the CRC. When the CRC matches and the type is legal, it delivers the decoded commands and data for one cycle. A frame with a CRC mismatch, or with the reserved type, is dropped and a single error pulse is raised instead. Both halves share one top level so the lanes can be looped back or driven on their own.

Top module: `sbf_frame_link`

## Requirements
- R1: A frame is 120 bits with the type in [119:118], the command in [117:94], the 72-bit field in [93:22] and the CRC in [21:0]. Beat k (k = 0..11) carries frame bits [10k+9:10k] on `lane_out`. The twelve beats come on consecutive cycles with `lane_out_valid` high, and `lane_out_first` is high on beat 0 only.
- R2: The CRC uses generator polynomial 0x2D4AB7 (x^22 implied) and starts from all ones. It takes the payload bits from bit 119 of the frame downward, without reflection and without a final inversion.
- R3: The packer zeroes field bits the type does not use. Type 00 carries three commands and clears field[23:0]. Type 10 carries two commands plus 36 data bits and clears field[47:36]. Types 01 and 11 pass the field unchanged.
- R4: `tx_ready` is high when no frame is in flight and on the last beat of a frame, and low on beats 0 to 10. A payload is accepted on a clock edge with `tx_valid` and `tx_ready` both high. Its beat 0 appears in the next cycle, so held payloads go out back to back with no idle beat.
- R5: The receiver starts a frame on a beat with `lane_in_valid` and `lane_in_first` both high, and counts eleven more valid beats. One cycle after the edge that captures the twelfth beat, it pulses one of `rx_valid`, `crc_error` or `type_error` for exactly one cycle.
- R6: With `rx_valid`, the decoded outputs depend on the type. Type 00 gives count 3, cmd_b = field[71:48], cmd_c = field[47:24] and data = 0. Type 01 gives count 1, cmd_b = cmd_c = 0 and data = field. Type 10 gives count 2, cmd_b = field[71:48], cmd_c = 0 and data = {36'b0, field[35:0]}. `rx_cmd_a` is always the command.
- R7: On a CRC mismatch the receiver pulses `crc_error` and gives no `rx_valid`, whatever the type bits read. This takes precedence over R8.
- R8: A frame with a matching CRC and type 11 pulses `type_error` and gives no `rx_valid`.
- R9: A beat marked first in the middle of a frame discards the beats collected so far and starts a new frame. The discarded part raises no error.
- R10: Valid beats that arrive with no frame started and without the first mark are ignored, and no result or error pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_valid | input | 1 | Payload offered |
| tx_ready | output | 1 | Payload can be taken this cycle |
| tx_type | input | 2 | Frame type |
| tx_cmd | input | 24 | Lead command |
| tx_field | input | 72 | Type-dependent commands/data |
| lane_out | output | 10 | Outgoing lane beat |
| lane_out_valid | output | 1 | Outgoing beat present |
| lane_out_first | output | 1 | Outgoing beat is beat 0 |
| lane_in | input | 10 | Incoming lane beat |
| lane_in_valid | input | 1 | Incoming beat present |
| lane_in_first | input | 1 | Incoming beat is beat 0 |
| rx_valid | output | 1 | Good frame delivered (one cycle) |
| rx_cmd_count | output | 2 | Number of commands in the frame |
| rx_cmd_a | output | 24 | Lead command |
| rx_cmd_b | output | 24 | Second command or zero |
| rx_cmd_c | output | 24 | Third command or zero |
| rx_data | output | 72 | Write data or zero |
| crc_error | output | 1 | CRC mismatch, frame dropped (one cycle) |
| type_error | output | 1 | Reserved type, frame dropped (one cycle) |

## Verification
Two events fall in the same cycle when payloads are held back to back. The packer takes the next payload on the last beat of the current frame. At the same time, the receiver reports the result for one frame while it captures beat 0 of the next. The bench loops the lanes back and keeps `tx_valid` high across two payloads. It then checks that the lane shows no gap and that `tx_ready` is low mid-frame. It also checks that the first frame's decoded result appears in the same cycle as the second frame's first beat, and that the second result follows twelve cycles later.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  localparam int LANES    = 10;
  localparam int BEATS    = 12;
  localparam int FRAME_W  = LANES * BEATS;
  localparam int TYPE_W   = 2;
  localparam int CMD_W    = 24;
  localparam int FIELD_W  = 72;
  localparam int PAY_W    = TYPE_W + CMD_W + FIELD_W;
  localparam int CRC_W    = FRAME_W - PAY_W;
  localparam int DATA36_W = FIELD_W / 2;
  localparam int BEAT_CW  = $clog2(BEATS);
  localparam logic [CRC_W-1:0] CRC_POLY = 22'h2D4AB7;
  localparam logic [CRC_W-1:0] CRC_INIT = '1;

  typedef enum logic [TYPE_W-1:0] {
    FT_TRIPLE_CMD = 2'b00,
    FT_CMD_DATA   = 2'b01,
    FT_DUAL_DATA  = 2'b10,
    FT_RESERVED   = 2'b11
  } ftype_e;

  typedef struct packed {
    logic [1:0]         count;
    logic [CMD_W-1:0]   cmd_b;
    logic [CMD_W-1:0]   cmd_c;
    logic [FIELD_W-1:0] data;
  } rx_dec_t;

  // Clear the field bits a frame type leaves unused.
  function automatic logic [FIELD_W-1:0] mask_field(input ftype_e t,
                                                     input logic [FIELD_W-1:0] f);
    logic [FIELD_W-1:0] m;
    m = f;
    case (t)
      FT_TRIPLE_CMD: m[FIELD_W-2*CMD_W-1:0] = '0;
      FT_DUAL_DATA:  m[FIELD_W-CMD_W-1:DATA36_W] = '0;
      default:       m = f;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/sbf_crc_gen.sv
module sbf_crc_gen #(
  parameter int                 DATA_W = 98,
  parameter int                 CRC_W  = 22,
  parameter logic [CRC_W-1:0]   POLY   = '1,
  parameter logic [CRC_W-1:0]   INIT   = '1
) (
  input  logic [DATA_W-1:0] data,
  output logic [CRC_W-1:0]  crc
);
  // Bit-serial division unrolled over the whole payload, MSB first.
  always_comb begin
    logic [CRC_W-1:0] c;
    logic             fb;
    c = INIT;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ data[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    crc = c;
  end
endmodule

// File: rtl/sbf_packer.sv
module sbf_packer
  import sbf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [TYPE_W-1:0]   tx_type,
  input  logic [CMD_W-1:0]    tx_cmd,
  input  logic [FIELD_W-1:0]  tx_field,
  output logic [LANES-1:0]    lane_out,
  output logic                lane_out_valid,
  output logic                lane_out_first
);
  logic [FRAME_W-1:0] shift_q, shift_d;
  logic [BEAT_CW-1:0] beat_q, beat_d;
  logic               busy_q, busy_d;
  logic               last_beat, accept;
  logic [PAY_W-1:0]   payload;
  logic [CRC_W-1:0]   crc;

  assign payload = {tx_type, tx_cmd, mask_field(ftype_e'(tx_type), tx_field)};

  sbf_crc_gen #(
    .DATA_W(PAY_W), .CRC_W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)
  ) crc_i (
    .data(payload),
    .crc (crc)
  );

  assign last_beat = busy_q && (beat_q == BEAT_CW'(BEATS - 1));
  assign tx_ready  = !busy_q || last_beat;
  assign accept    = tx_valid && tx_ready;

  always_comb begin
    shift_d = shift_q;
    beat_d  = beat_q;
    busy_d  = busy_q;
    if (accept) begin
      shift_d = {payload, crc};
      beat_d  = '0;
      busy_d  = 1'b1;
    end else if (busy_q) begin
      if (last_beat) begin
        busy_d = 1'b0;
        beat_d = '0;
      end else begin
        beat_d  = beat_q + BEAT_CW'(1);
        shift_d = shift_q >> LANES;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      beat_q  <= '0;
      busy_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      beat_q <= beat_d;
      if (accept || busy_q) shift_q <= shift_d;
    end
  end

  assign lane_out       = shift_q[LANES-1:0];
  assign lane_out_valid = busy_q;
  assign lane_out_first = busy_q && (beat_q == '0);

  p_accept_starts_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> lane_out_first);
  p_first_is_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lane_out_first |-> lane_out_valid);
  p_beats_contiguous_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lane_out_first |=> (lane_out_valid && !lane_out_first));
  p_ready_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lane_out_first |-> !tx_ready);
endmodule

// File: rtl/sbf_unpacker.sv
module sbf_unpacker
  import sbf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANES-1:0]   lane_in,
  input  logic               lane_in_valid,
  input  logic               lane_in_first,
  output logic               rx_valid,
  output logic [1:0]         rx_cmd_count,
  output logic [CMD_W-1:0]   rx_cmd_a,
  output logic [CMD_W-1:0]   rx_cmd_b,
  output logic [CMD_W-1:0]   rx_cmd_c,
  output logic [FIELD_W-1:0] rx_data,
  output logic               crc_error,
  output logic               type_error
);
  localparam int ACC_W = FRAME_W - LANES;

  logic [ACC_W-1:0]   acc_q, acc_d;
  logic [BEAT_CW-1:0] cnt_q, cnt_d;
  logic               act_q, act_d;
  logic               done;
  logic [FRAME_W-1:0] full;
  logic [PAY_W-1:0]   payload;
  logic [CRC_W-1:0]   crc_calc;
  logic               crc_ok;
  ftype_e             ftype;
  logic [CMD_W-1:0]   cmd;
  logic [FIELD_W-1:0] field;
  rx_dec_t            dec;

  // Gather beats: beat 0 ends up in the low bits once twelve are in.
  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    act_d = act_q;
    done  = 1'b0;
    if (lane_in_valid) begin
      acc_d = {lane_in, acc_q[ACC_W-1:LANES]};
      if (lane_in_first) begin
        cnt_d = BEAT_CW'(1);
        act_d = 1'b1;
      end else if (act_q) begin
        if (cnt_q == BEAT_CW'(BEATS - 1)) begin
          done  = 1'b1;
          act_d = 1'b0;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + BEAT_CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      if (lane_in_valid) acc_q <= acc_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign full    = {lane_in, acc_q};
  assign payload = full[FRAME_W-1:CRC_W];
  assign ftype   = ftype_e'(payload[PAY_W-1 -: TYPE_W]);
  assign cmd     = payload[PAY_W-TYPE_W-1 -: CMD_W];
  assign field   = payload[FIELD_W-1:0];

  sbf_crc_gen #(
    .DATA_W(PAY_W), .CRC_W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)
  ) crc_i (
    .data(payload),
    .crc (crc_calc)
  );

  assign crc_ok = (crc_calc == full[CRC_W-1:0]);

  always_comb begin
    dec = '0;
    case (ftype)
      FT_TRIPLE_CMD: begin
        dec.count = 2'd3;
        dec.cmd_b = field[FIELD_W-1 -: CMD_W];
        dec.cmd_c = field[FIELD_W-CMD_W-1 -: CMD_W];
      end
      FT_CMD_DATA: begin
        dec.count = 2'd1;
        dec.data  = field;
      end
      FT_DUAL_DATA: begin
        dec.count = 2'd2;
        dec.cmd_b = field[FIELD_W-1 -: CMD_W];
        dec.data  = {{(FIELD_W-DATA36_W){1'b0}}, field[DATA36_W-1:0]};
      end
      default: dec = '0;
    endcase
  end

  logic vld_d, cerr_d, terr_d;
  assign cerr_d = done && !crc_ok;
  assign terr_d = done && crc_ok && (ftype == FT_RESERVED);
  assign vld_d  = done && crc_ok && (ftype != FT_RESERVED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid     <= 1'b0;
      crc_error    <= 1'b0;
      type_error   <= 1'b0;
      rx_cmd_count <= '0;
      rx_cmd_a     <= '0;
      rx_cmd_b     <= '0;
      rx_cmd_c     <= '0;
      rx_data      <= '0;
    end else begin
      rx_valid   <= vld_d;
      crc_error  <= cerr_d;
      type_error <= terr_d;
      if (vld_d) begin
        rx_cmd_count <= dec.count;
        rx_cmd_a     <= cmd;
        rx_cmd_b     <= dec.cmd_b;
        rx_cmd_c     <= dec.cmd_c;
        rx_data      <= dec.data;
      end
    end
  end

  p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, crc_error, type_error}));
  p_outcome_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid || crc_error || type_error) |=> !(rx_valid || crc_error || type_error));
  p_outcome_follows_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid || crc_error || type_error) |-> $past(lane_in_valid));
  p_count_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_cmd_count != 2'd0));
endmodule

// File: rtl/sbf_frame_link.sv
module sbf_frame_link
  import sbf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [TYPE_W-1:0]  tx_type,
  input  logic [CMD_W-1:0]   tx_cmd,
  input  logic [FIELD_W-1:0] tx_field,
  output logic [LANES-1:0]   lane_out,
  output logic               lane_out_valid,
  output logic               lane_out_first,
  input  logic [LANES-1:0]   lane_in,
  input  logic               lane_in_valid,
  input  logic               lane_in_first,
  output logic               rx_valid,
  output logic [1:0]         rx_cmd_count,
  output logic [CMD_W-1:0]   rx_cmd_a,
  output logic [CMD_W-1:0]   rx_cmd_b,
  output logic [CMD_W-1:0]   rx_cmd_c,
  output logic [FIELD_W-1:0] rx_data,
  output logic               crc_error,
  output logic               type_error
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  // Assert asynchronously, release on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  sbf_packer pack_i (
    .clk            (clk),
    .rst_n          (rst_core_n),
    .tx_valid       (tx_valid),
    .tx_ready       (tx_ready),
    .tx_type        (tx_type),
    .tx_cmd         (tx_cmd),
    .tx_field       (tx_field),
    .lane_out       (lane_out),
    .lane_out_valid (lane_out_valid),
    .lane_out_first (lane_out_first)
  );

  sbf_unpacker unpack_i (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .lane_in       (lane_in),
    .lane_in_valid (lane_in_valid),
    .lane_in_first (lane_in_first),
    .rx_valid      (rx_valid),
    .rx_cmd_count  (rx_cmd_count),
    .rx_cmd_a      (rx_cmd_a),
    .rx_cmd_b      (rx_cmd_b),
    .rx_cmd_c      (rx_cmd_c),
    .rx_data       (rx_data),
    .crc_error     (crc_error),
    .type_error    (type_error)
  );
endmodule

// File: tb/sbf_frame_link_tb_top.sv
`timescale 1ns/1ps
module sbf_frame_link_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         tx_valid;
  logic         tx_ready;
  logic [1:0]   tx_type;
  logic [23:0]  tx_cmd;
  logic [71:0]  tx_field;
  logic [9:0]   lane_out;
  logic         lane_out_valid, lane_out_first;
  logic [9:0]   lane_in;
  logic         lane_in_valid, lane_in_first;
  logic         rx_valid, crc_error, type_error;
  logic [1:0]   rx_cmd_count;
  logic [23:0]  rx_cmd_a, rx_cmd_b, rx_cmd_c;
  logic [71:0]  rx_data;

  logic         ovr;
  logic [9:0]   m_data, flip;
  logic         m_valid, m_first;
  int           n_tests = 0;
  int           n_fail  = 0;
  bit           finished = 0;

  always #2.5 clk = ~clk;

  assign lane_in       = ovr ? m_data  : (lane_out ^ flip);
  assign lane_in_valid = ovr ? m_valid : lane_out_valid;
  assign lane_in_first = ovr ? m_first : lane_out_first;

  sbf_frame_link dut_i (.*);

  // {type, cmd, field, flip mask, flip beat}
  localparam logic [111:0] VEC [0:7] = '{
    {2'b01, 24'hA1B2C3, 72'h0123456789ABCDEF01, 10'h000, 4'd0},
    {2'b00, 24'h111111, 72'hFFEEDDCCBBAA998877, 10'h000, 4'd0},
    {2'b10, 24'h5A5A5A, 72'h123456789ABCDEF123, 10'h000, 4'd0},
    {2'b11, 24'h000001, 72'h000000000000000000, 10'h000, 4'd0},
    {2'b01, 24'hFFFFFF, 72'hFFFFFFFFFFFFFFFFFF, 10'h001, 4'd0},
    {2'b10, 24'h000000, 72'h000000000000000000, 10'h200, 4'd11},
    {2'b00, 24'h000000, 72'h000000000000000000, 10'h000, 4'd0},
    {2'b11, 24'hC0FFEE, 72'h00000000000000ABCD, 10'h040, 4'd6}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [21:0] ref_crc(input logic [97:0] p);
    logic [21:0] c;
    logic        fb;
    c = '1;
    for (int i = 97; i >= 0; i--) begin
      fb = c[21] ^ p[i];
      c  = c << 1;
      if (fb) c = c ^ 22'h2D4AB7;
    end
    return c;
  endfunction

  function automatic logic [71:0] ref_mask(input logic [1:0] t, input logic [71:0] f);
    logic [71:0] m;
    m = f;
    if (t == 2'b00) m[23:0] = '0;
    if (t == 2'b10) m[47:36] = '0;
    return m;
  endfunction

  function automatic logic [119:0] ref_frame(input logic [1:0] t, input logic [23:0] c,
                                             input logic [71:0] f);
    logic [97:0] p;
    p = {t, c, ref_mask(t, f)};
    return {p, ref_crc(p)};
  endfunction

  // Check one outcome cycle against R5-R8.
  task automatic chk_rx(input logic [1:0] t, input logic [23:0] c, input logic [71:0] f,
                        input bit corrupt, input string tag);
    logic [71:0] m;
    logic [1:0]  ec;
    logic [23:0] eb, ecc;
    logic [71:0] ed;
    m = ref_mask(t, f);
    if (corrupt) begin
      chk(crc_error && !rx_valid && !type_error, "R7", {tag, " crc_error only"},
          {rx_valid, crc_error, type_error}, 3'b010);
    end else if (t == 2'b11) begin
      chk(type_error && !rx_valid && !crc_error, "R8", {tag, " type_error only"},
          {rx_valid, crc_error, type_error}, 3'b001);
    end else begin
      chk(rx_valid && !crc_error && !type_error, "R5", {tag, " rx_valid only"},
          {rx_valid, crc_error, type_error}, 3'b100);
      eb = '0; ecc = '0; ed = '0;
      case (t)
        2'b00: begin ec = 2'd3; eb = m[71:48]; ecc = m[47:24]; end
        2'b01: begin ec = 2'd1; ed = m; end
        default: begin ec = 2'd2; eb = m[71:48]; ed = {36'b0, m[35:0]}; end
      endcase
      chk({rx_cmd_count, rx_cmd_a, rx_cmd_b, rx_cmd_c, rx_data} == {ec, c, eb, ecc, ed},
          "R6", {tag, " decoded fields"},
          {rx_cmd_count, rx_cmd_a, rx_cmd_b, rx_cmd_c, rx_data[31:0]},
          {ec, c, eb, ecc, ed[31:0]});
    end
  endtask

  task automatic run_frame(input logic [1:0] t, input logic [23:0] c, input logic [71:0] f,
                           input logic [9:0] fm, input int fb, input string tag);
    logic [119:0] got, exp;
    bit           shape_ok;
    exp = ref_frame(t, c, f);
    @(negedge clk);
    chk(tx_ready, "R4", {tag, " ready when idle"}, tx_ready, 1);
    tx_type = t; tx_cmd = c; tx_field = f; tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    got = '0;
    shape_ok = 1;
    for (int k = 0; k < 12; k++) begin
      if (k > 0) @(negedge clk);
      got[k*10 +: 10] = lane_out;
      if (!lane_out_valid || (lane_out_first != (k == 0))) shape_ok = 0;
      flip = (fm != 0 && k == fb) ? fm : 10'h000;
    end
    @(negedge clk);
    flip = 10'h000;
    chk(shape_ok, "R1", {tag, " beat valid/first marks"}, shape_ok, 1);
    chk(got == exp, "R2", {tag, " frame bits and CRC (R1 R3 layout)"}, got, exp);
    chk_rx(t, c, f, fm != 0, tag);
    @(negedge clk);
    chk(!rx_valid && !crc_error && !type_error, "R5", {tag, " pulse one cycle"},
        {rx_valid, crc_error, type_error}, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  initial begin
    logic [119:0] fa, fbx, got_a, got_b;
    bit           r9_quiet, r10_quiet;
    rst_n = 1'b0; tx_valid = 1'b0; tx_type = '0; tx_cmd = '0; tx_field = '0;
    ovr = 1'b0; m_data = '0; m_valid = 1'b0; m_first = 1'b0; flip = '0;
    repeat (4) @(negedge clk);
    chk(tx_ready && !lane_out_valid && !rx_valid && !crc_error && !type_error,
        "R4", "reset state", {tx_ready, lane_out_valid, rx_valid, crc_error, type_error},
        5'b10000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table of frames: layout, masking, CRC, decode, errors.
    for (int v = 0; v < 8; v++) begin
      run_frame(VEC[v][111:110], VEC[v][109:86], VEC[v][85:14], VEC[v][13:4],
                int'(VEC[v][3:0]), $sformatf("vec%0d", v));
    end

    // Back-to-back: accept on the last beat while the receiver reports.
    fa  = ref_frame(2'b01, 24'h123456, 72'hDEADBEEFCAFEF00D12);
    fbx = ref_frame(2'b00, 24'h654321, 72'h0F0E0D0C0B0A090807);
    @(negedge clk);
    tx_type = 2'b01; tx_cmd = 24'h123456; tx_field = 72'hDEADBEEFCAFEF00D12; tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_type = 2'b00; tx_cmd = 24'h654321; tx_field = 72'h0F0E0D0C0B0A090807;
    got_a = '0; got_b = '0;
    for (int j = 1; j <= 24; j++) begin
      if (j > 1) @(negedge clk);
      if (j <= 12) got_a[(j-1)*10 +: 10] = lane_out;
      else         got_b[(j-13)*10 +: 10] = lane_out;
      if (j == 5)  chk(!tx_ready, "R4", "ready low mid-frame", tx_ready, 0);
      if (j == 12) chk(tx_ready, "R4", "ready on last beat", tx_ready, 1);
      if (j == 13) begin
        tx_valid = 1'b0;
        chk(lane_out_first && lane_out_valid, "R4", "no gap between frames",
            {lane_out_valid, lane_out_first}, 2'b11);
        chk_rx(2'b01, 24'h123456, 72'hDEADBEEFCAFEF00D12, 0, "b2b first");
      end
    end
    @(negedge clk);
    chk_rx(2'b00, 24'h654321, 72'h0F0E0D0C0B0A090807, 0, "b2b second");
    chk(got_a == fa, "R1", "b2b frame A beats", got_a, fa);
    chk(got_b == fbx, "R1", "b2b frame B beats", got_b, fbx);

    // R9: partial frame restarted by a new first mark.
    fa = ref_frame(2'b10, 24'hABCDEF, 72'h112233445566778899);
    ovr = 1'b1;
    r9_quiet = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (rx_valid || crc_error || type_error) r9_quiet = 0;
      m_valid = 1'b1; m_first = (k == 0); m_data = 10'(k * 97 + 3);
    end
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (rx_valid || crc_error || type_error) r9_quiet = 0;
      m_first = (k == 0); m_data = fa[k*10 +: 10];
    end
    @(negedge clk);
    m_valid = 1'b0; m_first = 1'b0;
    chk(r9_quiet, "R9", "no pulse for discarded partial", r9_quiet, 1);
    chk_rx(2'b10, 24'hABCDEF, 72'h112233445566778899, 0, "R9 restarted");

    // R10: unmarked beats while idle are ignored.
    r10_quiet = 1;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      if (rx_valid || crc_error || type_error) r10_quiet = 0;
      m_valid = (k < 12); m_first = 1'b0; m_data = fa[(k % 12)*10 +: 10];
    end
    repeat (2) begin
      @(negedge clk);
      if (rx_valid || crc_error || type_error) r10_quiet = 0;
    end
    chk(r10_quiet, "R10", "unmarked beats ignored", r10_quiet, 1);
    ovr = 1'b0;
    run_frame(2'b01, 24'h0A0B0C, 72'h55AA55AA55AA55AA55, 10'h000, 0, "R10 after");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule